// File: doc/BRIEF.md
# Periodic RF Sniff Wake Controller

This block runs the low-power receive duty cycle of a radio front end from a slow tick clock. While the chip sleeps it counts a programmed interval, powers the receiver, lets the analog path settle for a programmed number of ticks, and then samples a single-bit RF-energy comparator. If no energy is present, the receiver is switched off again and the interval starts over. If energy is present, the receiver stays on for continuous reception and a wake is flagged to the host.

A second, independent housekeeping timer can also wake the host. The two wake causes share one indication line with opposite levels: high means RF and low means housekeeping. After either wake, the block overrides the shared data pin with the cause level for a programmed hold time. The pin then returns to its normal function. The host acknowledges a wake by holding its bus clock low, shown here as `host_clr`. This clears the wake and restarts sleep sequencing. Optionally, the raw comparator can be routed to the pin while a sniff is in progress.

All outputs are registered. A tick is one period of `clk`, typically 0.5 ms.

Top module: `sniff_wake_ctrl`

## Requirements
- R1: After a synchronous reset, `rx_en`, `wake_pending`, `wake_rf` and `pin_override` are 0 and the block is sleeping.
- R2: While sleeping with `cfg_interval_n` = N > 0, `rx_en` rises after exactly N×step ticks from entering sleep. The step is 1 tick when `cfg_interval_long` = 0 and LONG_STEP ticks (default 128) when it is 1.
- R3: With `cfg_interval_n` = 0 no sniff is started and `rx_en` stays 0.
- R4: A sniff holds `rx_en` high for `cfg_settle`+1 settle ticks plus one sample tick. The comparator is evaluated only in the sample tick, so energy seen during settling has no effect.
- R5: If the comparator is 0 in the sample tick, `rx_en` falls on the next edge and the interval count restarts from zero.
- R6: If the comparator is 1 in the sample tick, `rx_en` stays high and `wake_pending` and `wake_rf` become 1 on the next edge.
- R7: With `cfg_hk_period` = H > 0, every H consecutive ticks without a pending wake produce a wake with `wake_rf` = 0 and `rx_en` = 0. H = 0 disables the timer. The timer restarts when a wake is cleared.
- R8: For `cfg_hold` ticks after a wake, `pin_override` is 1 and `pin_level` equals the cause (1 for RF, 0 for housekeeping).
- R9: When there is no override, `pin_level` is the comparator input during settle and sample ticks if `cfg_cmp_route` = 1. Otherwise it is `data_normal`. In both cases the value is registered one tick late.
- R10: `host_clr` while a wake is pending returns the block to sleep on the next edge: `wake_pending`, `rx_en` and `pin_override` drop to 0. `host_clr` with no wake pending is ignored.
- R11: When an RF detect and a housekeeping expiry fall in the same tick, the RF wake wins: `wake_rf` = 1 and `rx_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval_n | input | N_W | Sniff interval count, 0 disables sniffing |
| cfg_interval_long | input | 1 | Interval step select: 0 = 1 tick, 1 = LONG_STEP ticks |
| cfg_settle | input | SETTLE_W | Settle ticks before sampling (minus one) |
| cfg_hold | input | HOLD_W | Ticks the pin holds the wake cause |
| cfg_hk_period | input | HK_W | Housekeeping period in ticks, 0 disables |
| cfg_cmp_route | input | 1 | Route comparator to pin during a sniff |
| rf_energy | input | 1 | RF-energy comparator result |
| host_clr | input | 1 | Host acknowledge (bus clock held low) |
| data_normal | input | 1 | Normal data destined for the shared pin |
| rx_en | output | 1 | Receiver power enable |
| wake_pending | output | 1 | A wake is awaiting host acknowledge |
| wake_rf | output | 1 | Wake cause: 1 RF, 0 housekeeping |
| pin_override | output | 1 | Pin currently shows the wake cause |
| pin_level | output | 1 | Value driven onto the shared data pin |

## Verification
The sample tick of a sniff and the expiry of the housekeeping timer can land on the same edge. Only one cause can be reported, so this collision is the point of interest. The bench provokes it deliberately: with a one-tick interval, zero settle and a three-tick housekeeping period, the first sample after a clear lines up with the expiry while the comparator is held high. It then expects an RF wake with the receiver still powered. The behavioural reference model resolves the same tick on every clock, so any priority inversion or lost wake appears as a mismatch on `wake_rf` or `rx_en`.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SAMPLE = 3'd2,
    ST_RX     = 3'd3,
    ST_HKWAKE = 3'd4
  } sniff_st_e;
endpackage

// File: rtl/sniff_interval_timer.sv
module sniff_interval_timer #(
  parameter int N_W       = 8,
  parameter int LONG_STEP = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [N_W-1:0] cfg_n,
  input  logic           cfg_long,
  output logic           expire
);
  localparam int P_W = N_W + $clog2(LONG_STEP) + 1;

  logic [P_W-1:0] cnt;
  logic [P_W-1:0] period;
  logic           enabled;

  // Period of one sleep phase in ticks; a power-of-two step becomes a shift.
  generate
    if ((LONG_STEP & (LONG_STEP - 1)) == 0) begin : g_shift
      always_comb
        period = cfg_long ? (P_W'(cfg_n) << $clog2(LONG_STEP)) : P_W'(cfg_n);
    end else begin : g_mult
      always_comb
        period = cfg_long ? (P_W'(cfg_n) * P_W'(LONG_STEP)) : P_W'(cfg_n);
    end
  endgenerate

  assign enabled = (cfg_n != '0);
  assign expire  = run && enabled && (cnt >= period - P_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (run && enabled && !expire) cnt <= cnt + P_W'(1);
    else                             cnt <= '0;
  end
endmodule

// File: rtl/sniff_hk_timer.sv
module sniff_hk_timer #(
  parameter int HK_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HK_W-1:0] cfg_period,
  output logic            expire
);
  logic [HK_W-1:0] cnt;
  logic            enabled;

  assign enabled = (cfg_period != '0);
  assign expire  = run && enabled && (cnt >= cfg_period - HK_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (run && enabled && !expire) cnt <= cnt + HK_W'(1);
    else                                cnt <= '0;
  end
endmodule

// File: rtl/sniff_pin_hold.sv
module sniff_pin_hold #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_evt,
  input  logic              cause_next,
  input  logic              clr,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              route_en,
  input  logic              rf_energy,
  input  logic              data_normal,
  output logic              pin_override,
  output logic              pin_level
);
  logic [HOLD_W-1:0] hold_cnt;
  logic [HOLD_W-1:0] hold_next;

  always_comb begin
    if (clr)                  hold_next = '0;
    else if (wake_evt)        hold_next = cfg_hold;
    else if (hold_cnt != '0)  hold_next = hold_cnt - HOLD_W'(1);
    else                      hold_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt     <= '0;
      pin_override <= 1'b0;
      pin_level    <= 1'b0;
    end else begin
      hold_cnt     <= hold_next;
      pin_override <= (hold_next != '0);
      if (hold_next != '0)  pin_level <= cause_next;
      else if (route_en)    pin_level <= rf_energy;
      else                  pin_level <= data_normal;
    end
  end
endmodule

// File: rtl/sniff_wake_ctrl.sv
module sniff_wake_ctrl
  import sniff_pkg::*;
#(
  parameter int N_W       = 8,
  parameter int LONG_STEP = 128,
  parameter int SETTLE_W  = 6,
  parameter int HOLD_W    = 8,
  parameter int HK_W      = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_W-1:0]      cfg_interval_n,
  input  logic                cfg_interval_long,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [HOLD_W-1:0]   cfg_hold,
  input  logic [HK_W-1:0]     cfg_hk_period,
  input  logic                cfg_cmp_route,
  input  logic                rf_energy,
  input  logic                host_clr,
  input  logic                data_normal,
  output logic                rx_en,
  output logic                wake_pending,
  output logic                wake_rf,
  output logic                pin_override,
  output logic                pin_level
);
  sniff_st_e           state, nxt;
  logic [SETTLE_W-1:0] st_cnt;
  logic                pending, ivl_exp, hk_exp;
  logic                wake_rf_evt, wake_hk_evt, clr_evt, cause_next, route_en;

  assign pending = (state == ST_RX) || (state == ST_HKWAKE);

  sniff_interval_timer #(.N_W(N_W), .LONG_STEP(LONG_STEP)) u_ivl (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_SLEEP),
    .cfg_n    (cfg_interval_n),
    .cfg_long (cfg_interval_long),
    .expire   (ivl_exp)
  );

  sniff_hk_timer #(.HK_W(HK_W)) u_hk (
    .clk        (clk),
    .rst        (rst),
    .run        (!pending),
    .cfg_period (cfg_hk_period),
    .expire     (hk_exp)
  );

  // RF detect outranks a housekeeping expiry in the same tick.
  assign wake_rf_evt = (state == ST_SAMPLE) && rf_energy;
  assign wake_hk_evt = hk_exp && !wake_rf_evt;
  assign clr_evt     = pending && host_clr;
  assign cause_next  = wake_rf_evt ? 1'b1 : (wake_hk_evt ? 1'b0 : wake_rf);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SLEEP:  if (hk_exp) nxt = ST_HKWAKE;
                 else if (ivl_exp) nxt = ST_SETTLE;
      ST_SETTLE: if (hk_exp) nxt = ST_HKWAKE;
                 else if (st_cnt >= cfg_settle) nxt = ST_SAMPLE;
      ST_SAMPLE: if (rf_energy) nxt = ST_RX;
                 else if (hk_exp) nxt = ST_HKWAKE;
                 else nxt = ST_SLEEP;
      ST_RX, ST_HKWAKE: if (host_clr) nxt = ST_SLEEP;
      default:   nxt = ST_SLEEP;
    endcase
  end

  assign route_en = cfg_cmp_route && ((nxt == ST_SETTLE) || (nxt == ST_SAMPLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_SLEEP;
      st_cnt       <= '0;
      rx_en        <= 1'b0;
      wake_pending <= 1'b0;
      wake_rf      <= 1'b0;
    end else begin
      state        <= nxt;
      st_cnt       <= (state == ST_SETTLE && nxt == ST_SETTLE) ? st_cnt + SETTLE_W'(1) : '0;
      rx_en        <= (nxt == ST_SETTLE) || (nxt == ST_SAMPLE) || (nxt == ST_RX);
      wake_pending <= (nxt == ST_RX) || (nxt == ST_HKWAKE);
      wake_rf      <= cause_next;
    end
  end

  sniff_pin_hold #(.HOLD_W(HOLD_W)) u_pin (
    .clk          (clk),
    .rst          (rst),
    .wake_evt     (wake_rf_evt || wake_hk_evt),
    .cause_next   (cause_next),
    .clr          (clr_evt),
    .cfg_hold     (cfg_hold),
    .route_en     (route_en),
    .rf_energy    (rf_energy),
    .data_normal  (data_normal),
    .pin_override (pin_override),
    .pin_level    (pin_level)
  );
endmodule

// File: rtl/sniff_wake_ctrl_chk.sv
module sniff_wake_ctrl_chk #(
  parameter int N_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [N_W-1:0] cfg_interval_n,
  input logic           rf_energy,
  input logic           host_clr,
  input logic           rx_en,
  input logic           wake_pending,
  input logic           wake_rf,
  input logic           pin_override,
  input logic           pin_level
);
  a_r3_no_sniff_when_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_interval_n == '0 && !rx_en) |=> !rx_en);

  a_r6_rf_wake_from_sample: assert property (@(posedge clk) disable iff (rst)
    ($rose(wake_pending) && wake_rf) |-> ($past(rf_energy) && $past(rx_en)));

  a_r6_rf_keeps_rx: assert property (@(posedge clk) disable iff (rst)
    (wake_pending && wake_rf) |-> rx_en);

  a_r7_hk_rx_off: assert property (@(posedge clk) disable iff (rst)
    (wake_pending && !wake_rf) |-> !rx_en);

  a_r8_override_cause: assert property (@(posedge clk) disable iff (rst)
    pin_override |-> (pin_level == wake_rf));

  a_r10_clear_sleeps: assert property (@(posedge clk) disable iff (rst)
    (wake_pending && host_clr) |=> (!wake_pending && !rx_en && !pin_override));

  a_r10_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (wake_pending && !host_clr) |=> (wake_pending && $stable(wake_rf)));
endmodule

bind sniff_wake_ctrl sniff_wake_ctrl_chk #(.N_W(N_W)) u_chk (.*);

// File: tb/sniff_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sniff_wake_ctrl_bench;
  localparam int LSTEP = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_interval_n = 8'd3;
  logic        cfg_interval_long = 1'b0;
  logic [5:0]  cfg_settle = 6'd2;
  logic [7:0]  cfg_hold = 8'd4;
  logic [15:0] cfg_hk_period = 16'd0;
  logic        cfg_cmp_route = 1'b1;
  logic        rf_energy = 1'b0;
  logic        host_clr = 1'b0;
  logic        data_normal = 1'b0;
  logic rx_en, wake_pending, wake_rf, pin_override, pin_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sniff_wake_ctrl u_sniff_wake_ctrl (
    .clk(clk), .rst(rst),
    .cfg_interval_n(cfg_interval_n), .cfg_interval_long(cfg_interval_long),
    .cfg_settle(cfg_settle), .cfg_hold(cfg_hold), .cfg_hk_period(cfg_hk_period),
    .cfg_cmp_route(cfg_cmp_route), .rf_energy(rf_energy), .host_clr(host_clr),
    .data_normal(data_normal), .rx_en(rx_en), .wake_pending(wake_pending),
    .wake_rf(wake_rf), .pin_override(pin_override), .pin_level(pin_level)
  );

  // Behavioural reference: 0 sleep, 1 settle, 2 sample, 3 rf-rx, 4 hk-wake
  int m_st = 0, m_ivl = 0, m_hk = 0, m_stc = 0, m_hold = 0;
  bit m_rx = 0, m_pend = 0, m_rf = 0, m_ovr = 0, m_pin = 0;

  always @(posedge clk) begin
    int per, nst, hold_n;
    bit pend, ie, he, rfw, hkw, clr, cause_n;
    if (rst) begin
      m_st = 0; m_ivl = 0; m_hk = 0; m_stc = 0; m_hold = 0;
      m_rx = 0; m_pend = 0; m_rf = 0; m_ovr = 0; m_pin = 0;
    end else begin
      pend = (m_st >= 3);
      per  = cfg_interval_long ? int'(cfg_interval_n) * LSTEP : int'(cfg_interval_n);
      ie   = (m_st == 0) && (cfg_interval_n != 0) && (m_ivl >= per - 1);
      he   = !pend && (cfg_hk_period != 0) && (m_hk >= int'(cfg_hk_period) - 1);
      rfw  = (m_st == 2) && rf_energy;
      hkw  = he && !rfw;
      clr  = pend && host_clr;
      nst  = m_st;
      case (m_st)
        0: if (he) nst = 4; else if (ie) nst = 1;
        1: if (he) nst = 4; else if (m_stc >= int'(cfg_settle)) nst = 2;
        2: if (rf_energy) nst = 3; else if (he) nst = 4; else nst = 0;
        default: if (host_clr) nst = 0;
      endcase
      cause_n = rfw ? 1'b1 : (hkw ? 1'b0 : m_rf);
      if (clr) hold_n = 0;
      else if (rfw || hkw) hold_n = int'(cfg_hold);
      else if (m_hold > 0) hold_n = m_hold - 1;
      else hold_n = 0;
      if (hold_n != 0) m_pin = cause_n;
      else if (cfg_cmp_route && (nst == 1 || nst == 2)) m_pin = rf_energy;
      else m_pin = data_normal;
      m_ovr  = (hold_n != 0);
      m_ivl  = (m_st == 0 && !ie && cfg_interval_n != 0) ? m_ivl + 1 : 0;
      m_hk   = (!pend && !he && cfg_hk_period != 0) ? m_hk + 1 : 0;
      m_stc  = (m_st == 1 && nst == 1) ? m_stc + 1 : 0;
      m_rx   = (nst == 1 || nst == 2 || nst == 3);
      m_pend = (nst >= 3);
      m_rf   = cause_n;
      m_hold = hold_n;
      m_st   = nst;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rx_en == m_rx, "R2 R4 R5 rx_en", rx_en, m_rx);
      chk(wake_pending == m_pend, "R6 R7 R10 wake_pending", wake_pending, m_pend);
      chk(wake_rf == m_rf, "R6 R7 R11 wake_rf", wake_rf, m_rf);
      chk(pin_override == m_ovr, "R8 pin_override", pin_override, m_ovr);
      chk(pin_level == m_pin, "R8 R9 pin_level", pin_level, m_pin);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      data_normal = ~data_normal;
    end
  endtask

  task automatic clear_wake();
    @(negedge clk); host_clr = 1'b1;
    @(negedge clk); host_clr = 1'b0;
  endtask

  initial begin
    int saw_rx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(rx_en == 0 && wake_pending == 0 && pin_override == 0 && wake_rf == 0,
        "R1 reset outputs", {rx_en, wake_pending, pin_override, wake_rf}, 0);

    // R2 R4 R5 R9: short interval, no energy, comparator routed
    run(60);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      rf_energy = (i % 7 == 3);
      data_normal = ~data_normal;
    end
    rf_energy = 1'b1;
    run(20);
    // R6: continuous energy must produce an RF wake
    chk(wake_pending && wake_rf && rx_en, "R6 rf wake", {wake_pending, wake_rf, rx_en}, 7);
    rf_energy = 1'b0;
    clear_wake();
    chk(!wake_pending && !rx_en, "R10 clear returns to sleep", {wake_pending, rx_en}, 0);
    // R10: clear without pending wake is ignored
    @(negedge clk); host_clr = 1'b1;
    run(4);
    host_clr = 1'b0;
    run(10);

    // R3 R7: sniffing off, housekeeping wakes
    @(negedge clk);
    cfg_interval_n = 8'd0; cfg_hk_period = 16'd50; cfg_hold = 8'd3;
    clear_wake();
    saw_rx = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      data_normal = ~data_normal;
      if (rx_en) saw_rx = 1;
    end
    chk(saw_rx == 0, "R3 no sniff with zero interval", saw_rx, 0);
    chk(wake_pending && !wake_rf && !rx_en, "R7 housekeeping wake",
        {wake_pending, wake_rf, rx_en}, 4);
    clear_wake();

    // R2: long step, no housekeeping
    cfg_hk_period = 16'd0; cfg_interval_n = 8'd2; cfg_interval_long = 1'b1;
    cfg_settle = 6'd5; cfg_cmp_route = 1'b0;
    run(600);
    rf_energy = 1'b1;
    run(300);
    chk(wake_pending && wake_rf, "R6 wake after long interval", {wake_pending, wake_rf}, 3);

    // R11: RF sample and housekeeping expiry in the same tick
    cfg_interval_n = 8'd1; cfg_interval_long = 1'b0; cfg_settle = 6'd0;
    cfg_hk_period = 16'd3; cfg_hold = 8'd2;
    clear_wake();
    run(10);
    chk(wake_pending && wake_rf && rx_en, "R11 rf wins collision",
        {wake_pending, wake_rf, rx_en}, 7);
    run(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule